// File: doc/BRIEF.md
# Mailbox Receive Outbox Queue

This block is the receive side of an inter-processor mailbox. Remote cores push 64-bit messages into it, and each message carries a 3-bit channel tag that says which channel it arrived on. The messages wait in a circular buffer. A local processor reads them through a small register window. It sees the oldest message (its two 32-bit halves and its channel tag) at fixed offsets, and a write to a trigger offset discards that message.

There is no occupancy counter. A status word shows the raw write pointer, the raw read pointer and a full flag. Software works out how many entries are held: when the pointers are equal, the full flag decides between "full" and "empty"; otherwise the count is the wrapped difference. A read-only depth word gives the capacity minus one. A level-sensitive, sticky not-empty interrupt can be masked and is cleared by software.

Register reads take two cycles. Writes take effect on the clock edge that samples them.

Top module: `mbox_rx_outbox`

## Requirements
- R1: After reset, the status word at offset 0x14 reads 0, the interrupt mask at 0x1C reads 0x1F, the interrupt status at 0x18 reads 0, `irq` is low and `push_ready` is high.
- R2: The oldest held message is read as follows: its bits 31:0 at offset 0x4, its bits 63:32 at 0x8, and its channel tag zero-extended at 0x0. Messages come out in the order they were accepted.
- R3: A write to offset 0xC with bit 0 set removes the oldest message and advances the read pointer. A write there with bit 0 clear has no effect, and so does a remove request while the queue is empty.
- R4: In the status word, bit 0 is the full flag, bits 23:16 hold the write pointer and bits 31:24 hold the read pointer. Both pointers wrap from DEPTH-1 to 0.
- R5: Once DEPTH messages are held, the full flag is set, the pointers are equal and `push_ready` is low. A push offered in that state is dropped: the pointers and the stored messages stay unchanged.
- R6: Offset 0x24 reads DEPTH-1.
- R7: Offset 0x1C holds a 5-bit mask that is read back as written. Mask bit 0 set stops the not-empty source from raising the interrupt.
- R8: The interrupt status bit (bit 0 of offset 0x18, also driven on `irq`) is set one cycle after any cycle in which the queue is non-empty while mask bit 0 is clear. It stays set after the queue drains. Writing 1 to bit 0 of 0x18 clears it, but it is set again if the condition still holds.
- R9: Writing the value 0 to offset 0x10 empties the queue, clearing both pointers and the full flag. Any non-zero value written there has no effect.
- R10: A push and a remove in the same cycle on a queue that is neither empty nor full are both performed, so the number of held messages does not change.
- R11: `reg_rvalid` is high exactly two cycles after a cycle with `reg_rd_en`. An offset that no register uses reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Remote core offers a message |
| push_data | input | 64 | Message payload |
| push_id | input | ID_W | Channel tag of the message |
| push_ready | output | 1 | Queue can accept a message (not full) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, two cycles after the strobe |
| irq | output | 1 | Sticky not-empty interrupt |

## Verification
The bench moves the pointers away from zero before it fills the queue. That way the full case is reached with equal, non-zero pointers and then drains across the wrap point. A design that decided full-versus-empty from the pointers alone, or that wrapped at the field width instead of at DEPTH, would report a wrong status word or return stale heads. Pushes offered while full must leave the head and the pointers as they were; a design that overwrote the oldest entry would return the wrong payload. The bench also checks the interrupt in several situations: while masked, when unmasked, when cleared with data still held, and after draining. A design that cleared without re-arming, or that made the bit follow the queue level instead of holding it, is caught there. Finally, a simultaneous push and remove must leave the full flag clear and both pointers advanced.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;

  localparam int REG_AW      = 6;
  localparam int REG_DW      = 32;
  localparam int MSG_W       = 64;
  localparam int PTR_FIELD_W = 8;
  localparam int IRQ_SRC_W   = 5;

  // Register offsets; software decodes these, so they are fixed.
  localparam logic [REG_AW-1:0] OFS_CHAN     = 6'h00;
  localparam logic [REG_AW-1:0] OFS_MSG_LO   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_MSG_HI   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_POP      = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_FIFO_RST = 6'h10;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_IRQ_ST   = 6'h18;
  localparam logic [REG_AW-1:0] OFS_IRQ_MSK  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_DEPTH    = 6'h24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CHAN,
    SEL_LO,
    SEL_HI,
    SEL_STATUS,
    SEL_IRQ_ST,
    SEL_IRQ_MSK,
    SEL_DEPTH
  } rd_sel_e;

  function automatic rd_sel_e decode_rd(input logic [REG_AW-1:0] a);
    rd_sel_e s;
    case (a)
      OFS_CHAN:    s = SEL_CHAN;
      OFS_MSG_LO:  s = SEL_LO;
      OFS_MSG_HI:  s = SEL_HI;
      OFS_STATUS:  s = SEL_STATUS;
      OFS_IRQ_ST:  s = SEL_IRQ_ST;
      OFS_IRQ_MSK: s = SEL_IRQ_MSK;
      OFS_DEPTH:   s = SEL_DEPTH;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mbox_rx_ram.sv
// Simple dual-port storage, synchronous write and registered read.
module mbox_rx_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 67,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mbox_rx_ptrs.sv
// Read/write pointers with a separate full flag; wrap modulo DEPTH.
module mbox_rx_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_acc,
  output logic             pop_acc,
  output logic [IDX_W-1:0] wptr,
  output logic [IDX_W-1:0] rptr,
  output logic             full,
  output logic             nonempty
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    if (p == LAST) begin
      return '0;
    end
    return p + 1'b1;
  endfunction

  logic [IDX_W-1:0] wptr_inc;
  logic [IDX_W-1:0] rptr_inc;

  assign wptr_inc = bump(wptr);
  assign rptr_inc = bump(rptr);
  assign nonempty = full | (wptr != rptr);
  assign push_acc = push_req & ~full;
  assign pop_acc  = pop_req & nonempty;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      wptr <= '0;
      rptr <= '0;
      full <= 1'b0;
    end else begin
      if (push_acc) begin
        wptr <= wptr_inc;
      end
      if (pop_acc) begin
        rptr <= rptr_inc;
      end
      if (push_acc && !pop_acc) begin
        full <= (wptr_inc == rptr);
      end else if (pop_acc && !push_acc) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbox_rx_irq.sv
// Interrupt mask register and sticky not-empty status.
module mbox_rx_irq #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nonempty,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_wdata,
  input  logic             clr,
  output logic [SRC_W-1:0] mask,
  output logic             pending
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '1;
      pending <= 1'b0;
    end else begin
      if (mask_we) begin
        mask <= mask_wdata;
      end
      // set has priority over clear so a held condition re-arms
      pending <= (pending & ~clr) | (nonempty & ~mask[0]);
    end
  end

endmodule

// File: rtl/mbox_rx_rdpath.sv
// Two-stage read path: snapshot and decode, then select.
module mbox_rx_rdpath
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int ID_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [REG_AW-1:0]     rd_addr,
  input  logic [ID_W+MSG_W-1:0] head,
  input  logic                  full,
  input  logic [IDX_W-1:0]      wptr,
  input  logic [IDX_W-1:0]      rptr,
  input  logic                  pending,
  input  logic [IRQ_SRC_W-1:0]  mask,
  output logic [REG_DW-1:0]     rdata,
  output logic                  rvalid
);

  localparam logic [REG_DW-1:0] DEPTH_WORD = REG_DW'(DEPTH - 1);

  rd_sel_e              s1_sel;
  logic                 s1_valid;
  logic [REG_DW-1:0]    s1_status;
  logic                 s1_pending;
  logic [IRQ_SRC_W-1:0] s1_mask;
  logic [REG_DW-1:0]    rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sel     <= SEL_NONE;
      s1_valid   <= 1'b0;
      s1_status  <= '0;
      s1_pending <= 1'b0;
      s1_mask    <= '0;
    end else begin
      s1_sel     <= decode_rd(rd_addr);
      s1_valid   <= rd_en;
      s1_status  <= {PTR_FIELD_W'(rptr), PTR_FIELD_W'(wptr), 15'd0, full};
      s1_pending <= pending;
      s1_mask    <= mask;
    end
  end

  always_comb begin
    case (s1_sel)
      SEL_CHAN:    rd_mux = REG_DW'(head[ID_W+MSG_W-1:MSG_W]);
      SEL_LO:      rd_mux = head[31:0];
      SEL_HI:      rd_mux = head[63:32];
      SEL_STATUS:  rd_mux = s1_status;
      SEL_IRQ_ST:  rd_mux = REG_DW'(s1_pending);
      SEL_IRQ_MSK: rd_mux = REG_DW'(s1_mask);
      SEL_DEPTH:   rd_mux = DEPTH_WORD;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= s1_valid ? rd_mux : '0;
      rvalid <= s1_valid;
    end
  end

endmodule

// File: rtl/mbox_rx_outbox.sv
module mbox_rx_outbox
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [MSG_W-1:0]  push_data,
  input  logic [ID_W-1:0]   push_id,
  output logic              push_ready,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int ENTRY_W = ID_W + MSG_W;

  if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
    $error("DEPTH must lie in 2..256");
  end

  logic                 pop_req;
  logic                 fifo_srst;
  logic                 irq_clr;
  logic                 mask_we;
  logic                 push_acc;
  logic                 pop_acc;
  logic [IDX_W-1:0]     wptr;
  logic [IDX_W-1:0]     rptr;
  logic                 full_q;
  logic                 fifo_nonempty;
  logic [ENTRY_W-1:0]   head;
  logic [IRQ_SRC_W-1:0] irq_mask;
  logic                 irq_pending;

  // write-side decode
  assign pop_req   = reg_wr_en && (reg_addr == OFS_POP) && reg_wdata[0];
  assign fifo_srst = reg_wr_en && (reg_addr == OFS_FIFO_RST) && (reg_wdata == '0);
  assign irq_clr   = reg_wr_en && (reg_addr == OFS_IRQ_ST) && reg_wdata[0];
  assign mask_we   = reg_wr_en && (reg_addr == OFS_IRQ_MSK);

  mbox_rx_ptrs #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) i_ptrs (
    .clk      (clk),
    .rst      (rst),
    .srst     (fifo_srst),
    .push_req (push_valid),
    .pop_req  (pop_req),
    .push_acc (push_acc),
    .pop_acc  (pop_acc),
    .wptr     (wptr),
    .rptr     (rptr),
    .full     (full_q),
    .nonempty (fifo_nonempty)
  );

  mbox_rx_ram #(
    .DEPTH (DEPTH),
    .WIDTH (ENTRY_W),
    .AW    (IDX_W)
  ) i_ram (
    .clk   (clk),
    .we    (push_acc),
    .waddr (wptr),
    .wdata ({push_id, push_data}),
    .raddr (rptr),
    .rdata (head)
  );

  mbox_rx_irq #(
    .SRC_W (IRQ_SRC_W)
  ) i_irq (
    .clk        (clk),
    .rst        (rst),
    .nonempty   (fifo_nonempty),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata[IRQ_SRC_W-1:0]),
    .clr        (irq_clr),
    .mask       (irq_mask),
    .pending    (irq_pending)
  );

  mbox_rx_rdpath #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .ID_W  (ID_W)
  ) i_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd_en),
    .rd_addr (reg_addr),
    .head    (head),
    .full    (full_q),
    .wptr    (wptr),
    .rptr    (rptr),
    .pending (irq_pending),
    .mask    (irq_mask),
    .rdata   (reg_rdata),
    .rvalid  (reg_rvalid)
  );

  assign push_ready = ~full_q;
  assign irq        = irq_pending;

endmodule

// File: rtl/mbox_rx_outbox_chk.sv
module mbox_rx_outbox_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             full,
  input logic             nonempty,
  input logic [IDX_W-1:0] wptr,
  input logic [IDX_W-1:0] rptr,
  input logic             srst,
  input logic             pop_req,
  input logic             mask0,
  input logic             irq,
  input logic             rd_en,
  input logic             rvalid
);

  AST_FULL_PTRS_EQ: assert property (@(posedge clk) disable iff (rst)
    full |-> (wptr == rptr)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && !srst) |=> $stable(wptr)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !nonempty && !srst) |=> $stable(rptr)); // R3

  AST_IRQ_ARMS: assert property (@(posedge clk) disable iff (rst)
    (nonempty && !mask0) |=> irq); // R8

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    srst |=> (wptr == '0 && rptr == '0 && !full)); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rvalid); // R11

endmodule

bind mbox_rx_outbox mbox_rx_outbox_chk #(.IDX_W(IDX_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .full     (full_q),
  .nonempty (fifo_nonempty),
  .wptr     (wptr),
  .rptr     (rptr),
  .srst     (fifo_srst),
  .pop_req  (pop_req),
  .mask0    (irq_mask[0]),
  .irq      (irq),
  .rd_en    (reg_rd_en),
  .rvalid   (reg_rvalid)
);

// File: tb/test_mbox_rx_outbox.sv
`timescale 1ns/1ps
module test_mbox_rx_outbox;

  localparam int DEPTH = 8;
  localparam int ID_W  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic [2:0]  push_id = '0;
  logic        push_ready;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model
  logic [63:0] q_data[$];
  logic [2:0]  q_id[$];
  int wp = 0;
  int rp = 0;

  always #4 clk = ~clk;

  mbox_rx_outbox #(.DEPTH(DEPTH), .ID_W(ID_W)) i_mbox_rx_outbox (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .push_data(push_data), .push_id(push_id),
    .push_ready(push_ready),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {8'(rp), 8'(wp), 15'd0, (q_data.size() == DEPTH)};
  endfunction

  function automatic logic [63:0] mk_msg(input int i);
    return {32'(i) * 32'h0101_0101 ^ 32'hC0DE_0000, 32'(i) + 32'h5A00_0000};
  endfunction

  task automatic model_push(input logic [63:0] d, input logic [2:0] id);
    if (q_data.size() < DEPTH) begin
      q_data.push_back(d);
      q_id.push_back(id);
      wp = (wp + 1) % DEPTH;
    end
  endtask

  task automatic model_pop();
    if (q_data.size() > 0) begin
      void'(q_data.pop_front());
      void'(q_id.pop_front());
      rp = (rp + 1) % DEPTH;
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    @(negedge clk);
    chk("R11", "rvalid two cycles after strobe", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic push(input logic [63:0] d, input logic [2:0] id);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_id = id;
    @(negedge clk);
    push_valid = 1'b0;
    model_push(d, id);
  endtask

  task automatic pop();
    reg_wr(6'h0C, 32'h1);
    model_pop();
  endtask

  task automatic check_status(input string req);
    logic [31:0] v;
    reg_rd(6'h14, v);
    chk(req, "status word", v, exp_status());
  endtask

  task automatic check_head(input string req);
    logic [31:0] v;
    reg_rd(6'h04, v);
    chk(req, "head low word", v, q_data[0][31:0]);
    reg_rd(6'h08, v);
    chk(req, "head high word", v, q_data[0][63:32]);
    reg_rd(6'h00, v);
    chk(req, "head channel", v, 32'(q_id[0]));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "push_ready after reset", 32'(push_ready), 32'd1);
    chk("R1", "irq after reset", 32'(irq), 32'd0);
    check_status("R1");
    reg_rd(6'h1C, v); chk("R1", "mask after reset", v, 32'h1F);
    reg_rd(6'h18, v); chk("R1", "irq status after reset", v, 32'h0);
    reg_rd(6'h24, v); chk("R6", "depth word", v, 32'(DEPTH - 1));
    reg_rd(6'h28, v); chk("R11", "unused offset", v, 32'h0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) push(mk_msg(i), 3'(i + 5));
    check_status("R4");
    for (int i = 0; i < 3; i++) begin
      check_head("R2");
      pop();
      check_status("R3");
    end
  endtask

  task automatic t_pop_ignored();
    push(mk_msg(20), 3'd2);
    reg_wr(6'h0C, 32'hFFFF_FFFE);   // bit 0 clear: R3 no effect
    check_status("R3");
    check_head("R3");
    pop();
    reg_wr(6'h0C, 32'h1);           // empty: R3 no effect
    check_status("R3");
  endtask

  task automatic t_full();
    logic [31:0] lo;
    for (int i = 0; i < DEPTH; i++) push(mk_msg(100 + i), 3'(i));
    chk("R5", "push_ready when full", 32'(push_ready), 32'd0);
    check_status("R5");
    push(64'hDEAD_BEEF_DEAD_BEEF, 3'd7);  // dropped
    check_status("R5");
    reg_rd(6'h04, lo);
    chk("R5", "head kept after dropped push", lo, mk_msg(100)[31:0]);
    for (int i = 0; i < DEPTH; i++) begin
      check_head("R4");
      pop();
    end
    check_status("R4");
    chk("R5", "push_ready after drain", 32'(push_ready), 32'd1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    push(mk_msg(40), 3'd1);
    @(negedge clk);
    chk("R7", "masked source keeps irq low", 32'(irq), 32'd0);
    reg_wr(6'h1C, 32'h1E);
    @(negedge clk);
    chk("R8", "irq after unmask", 32'(irq), 32'd1);
    reg_rd(6'h1C, v); chk("R7", "mask readback", v, 32'h1E);
    reg_rd(6'h18, v); chk("R8", "irq status bit", v, 32'h1);
    reg_wr(6'h18, 32'h1);
    @(negedge clk);
    chk("R8", "clear while non-empty re-arms", 32'(irq), 32'd1);
    pop();
    @(negedge clk);
    chk("R8", "sticky after drain", 32'(irq), 32'd1);
    reg_wr(6'h18, 32'h1);
    @(negedge clk);
    chk("R8", "cleared when empty", 32'(irq), 32'd0);
    reg_wr(6'h1C, 32'h1F);
    push(mk_msg(41), 3'd3);
    @(negedge clk);
    chk("R7", "remasked source keeps irq low", 32'(irq), 32'd0);
    pop();
  endtask

  task automatic t_soft_reset();
    push(mk_msg(60), 3'd4);
    push(mk_msg(61), 3'd6);
    reg_wr(6'h10, 32'h5);           // non-zero: R9 no effect
    check_status("R9");
    check_head("R9");
    reg_wr(6'h10, 32'h0);
    q_data.delete(); q_id.delete(); wp = 0; rp = 0;
    check_status("R9");
    push(mk_msg(62), 3'd2);
    check_head("R9");
  endtask

  task automatic t_simul();
    push(mk_msg(70), 3'd3);         // now two held
    @(negedge clk);
    push_valid = 1'b1; push_data = mk_msg(71); push_id = 3'd5;
    reg_wr_en = 1'b1; reg_addr = 6'h0C; reg_wdata = 32'h1;
    @(negedge clk);
    push_valid = 1'b0; reg_wr_en = 1'b0;
    model_pop();
    model_push(mk_msg(71), 3'd5);
    check_status("R10");
    check_head("R10");
    pop();
    check_head("R10");
    pop();
    check_status("R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_pop_ignored();
    t_full();
    t_irq();
    t_soft_reset();
    t_simul();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule